// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular region of local packet memory built from 256-byte pages. A host sets up the region with a first-page and an end-page value (the end page is one past the last ring page). The host keeps a read-progress page, called the boundary. The block keeps and advances the write-progress page, called the current page. Each stored frame is laid down as a 4-byte header followed by the payload. The header carries a status byte, the page where the next frame begins, and the stored length.

A frame is offered with `frm_sof` on its first byte and `frm_eof` on its last; `frm_valid` qualifies each byte. When the frame starts, the block decides whether to take it. It refuses the frame when the halt input is high, when the ring is degenerate, or when the free space between the current page and the boundary cannot hold a maximum-size frame. A refused frame is discarded up to its last byte. An accepted frame's payload is written first, one byte per valid beat, starting four bytes into its first page. After the last byte, `frm_busy` rises for four cycles while the header is written in front of the payload. In the last of these cycles `rx_done` pulses and the current page moves to the next-frame page.

Top module: `rx_ring_writer`

## Requirements
- R1: While `rx_halt` is 1 at the first byte of a frame, the frame is refused.
- R2: A frame is refused if `cfg_stop_pg` <= `cfg_start_pg`. It is also refused if the free space is below MAX_FRAME+4 = 1518 bytes. Free space is (boundary − current)·256 when current < boundary, and otherwise ((stop − start) − (current − boundary))·256.
- R3: The payload of an accepted frame is written byte by byte from address base·256+4 upward. When the address reaches stop·256 it continues at start·256.
- R4: The header is written only after the last payload byte. It takes exactly four cycles, at base·256+0..3, and `frm_busy` and `mem_we` are high in each of them.
- R5: Header byte 0 (status) is 0x01, or 0x21 when bit 0 of the first payload byte is 1.
- R6: Header byte 1 is the next page: base + ceil((len+8)/256), minus (stop − start) if the result is >= stop. Header bytes 2 and 3 are the low and high bytes of len+4.
- R7: In the last header cycle `rx_done` pulses for one cycle, and from the next cycle `cur_pg` equals the next page.
- R8: If `cur_pg` >= MEM_END_PG (0x80 by default) when a frame is accepted, the frame's base page is `cfg_start_pg` instead.
- R9: A refused frame causes no memory write and no `rx_done` pulse, and leaves `cur_pg` unchanged.
- R10: After reset, `cur_pg` is 0 and `frm_busy`, `mem_we` and `rx_done` are 0.
- R11: A cycle with `cur_wr_en` loads `cur_pg` from `cur_wr_pg`, unless a header is completing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_pg | input | 8 | First ring page |
| cfg_stop_pg | input | 8 | Last ring page plus one |
| cfg_bnd_pg | input | 8 | Host read-progress page |
| rx_halt | input | 1 | Receiver halted; new frames refused |
| cur_wr_en | input | 1 | Host load of the current page |
| cur_wr_pg | input | 8 | Value for the current page load |
| cur_pg | output | 8 | Current (write-progress) page |
| frm_valid | input | 1 | Byte valid |
| frm_sof | input | 1 | First byte of frame |
| frm_eof | input | 1 | Last byte of frame |
| frm_data | input | 8 | Frame byte |
| frm_busy | output | 1 | Header being written; stream must hold |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| rx_done | output | 1 | One-cycle frame-stored pulse |

## Verification
The assertions check every cycle that a busy cycle always writes memory and that `rx_done` only occurs inside the header phase. They also check that the current page changes only after a completed frame or a host load, and that a halted receiver issues no write at a frame start. Exact placement can only be shown by the bench's scenarios. These cover payload wrap at the ring end, the header contents and the next-page wrap. They also cover the free-space threshold on both sides of 1518 bytes and the fallback to the start page. In each case every observed write is compared against a behavioural model of the ring.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PG_W       = 8,
  parameter int MAX_FRAME  = 1514,
  parameter int MEM_END_PG = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PG_W-1:0]   cfg_start_pg,
  input  logic [PG_W-1:0]   cfg_stop_pg,
  input  logic [PG_W-1:0]   cfg_bnd_pg,
  input  logic              rx_halt,
  input  logic              cur_wr_en,
  input  logic [PG_W-1:0]   cur_wr_pg,
  output logic [PG_W-1:0]   cur_pg,
  input  logic              frm_valid,
  input  logic              frm_sof,
  input  logic              frm_eof,
  input  logic [7:0]        frm_data,
  output logic              frm_busy,
  output logic              mem_we,
  output logic [PG_W+7:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rx_done
);
  localparam int AW = PG_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_PAY, S_DROP, S_HDR} st_t;
  st_t st;

  logic [PG_W-1:0] base_pg, eff_pg, nxt_pg;
  logic [AW-1:0]   wptr, first_addr, ring_lo, ring_hi;
  logic [15:0]     len, tot;
  logic [1:0]      hidx;
  logic            mcast, full, accept, idle, start;
  logic [7:0]      hdr_byte;

  assign ring_lo    = {cfg_start_pg, 8'h00};
  assign ring_hi    = {cfg_stop_pg, 8'h00};
  assign eff_pg     = (int'(cur_pg) >= MEM_END_PG) ? cfg_start_pg : cur_pg;
  assign first_addr = {eff_pg, 8'h04};
  assign idle       = (st == S_IDLE);
  assign start      = idle && frm_valid && frm_sof;
  assign accept     = start && !rx_halt && !full;
  assign tot        = len + 16'd4;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    logic [AW-1:0] n;
    n = a + 1'b1;
    return (n == hi) ? lo : n;
  endfunction

  always_comb begin
    int fp;
    if (cur_pg < cfg_bnd_pg) fp = int'(cfg_bnd_pg) - int'(cur_pg);
    else fp = (int'(cfg_stop_pg) - int'(cfg_start_pg)) - (int'(cur_pg) - int'(cfg_bnd_pg));
    full = (cfg_stop_pg <= cfg_start_pg) || (fp * 256 < MAX_FRAME + 4);
  end

  always_comb begin
    int nx;
    nx = int'(base_pg) + ((int'(len) + 8 + 255) / 256);
    if (nx >= int'(cfg_stop_pg)) nx = nx - (int'(cfg_stop_pg) - int'(cfg_start_pg));
    nxt_pg = PG_W'(nx);
  end

  always_comb begin
    case (hidx)
      2'd0:    hdr_byte = mcast ? 8'h21 : 8'h01;
      2'd1:    hdr_byte = 8'(nxt_pg);
      2'd2:    hdr_byte = tot[7:0];
      default: hdr_byte = tot[15:8];
    endcase
  end

  assign frm_busy  = (st == S_HDR);
  assign rx_done   = frm_busy && (hidx == 2'd3);
  assign mem_we    = accept || (st == S_PAY && frm_valid) || frm_busy;
  assign mem_addr  = frm_busy ? {base_pg, 6'd0, hidx} : (st == S_PAY) ? wptr : first_addr;
  assign mem_wdata = frm_busy ? hdr_byte : frm_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_pg  <= '0;
      base_pg <= '0;
      wptr    <= '0;
      len     <= '0;
      hidx    <= '0;
      mcast   <= 1'b0;
    end else begin
      if (rx_done) cur_pg <= nxt_pg;
      else if (cur_wr_en) cur_pg <= cur_wr_pg;
      case (st)
        S_IDLE: if (start) begin
          if (accept) begin
            base_pg <= eff_pg;
            wptr    <= step(first_addr, ring_lo, ring_hi);
            len     <= 16'd1;
            mcast   <= frm_data[0];
            hidx    <= 2'd0;
            st      <= frm_eof ? S_HDR : S_PAY;
          end else begin
            st      <= frm_eof ? S_IDLE : S_DROP;
          end
        end
        S_PAY: if (frm_valid) begin
          wptr <= step(wptr, ring_lo, ring_hi);
          len  <= len + 16'd1;
          if (frm_eof) st <= S_HDR;
        end
        S_DROP: if (frm_valid && frm_eof) st <= S_IDLE;
        S_HDR: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_ring_writer_chk #(
  parameter int PG_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            we,
  input logic            done,
  input logic [PG_W-1:0] cur,
  input logic            ld,
  input logic            idle,
  input logic            valid,
  input logic            sof,
  input logic            halt
);
  a_r4_hdr_writes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> we);
  a_r4_hdr_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  a_r7_done_in_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_cur_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> $past(done || ld));
  a_r1_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && valid && sof && halt) |-> !we);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(frm_busy), .we(mem_we), .done(rx_done),
  .cur(cur_pg), .ld(cur_wr_en), .idle(idle), .valid(frm_valid),
  .sof(frm_sof), .halt(rx_halt)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] start_pg = 8'h46, stop_pg = 8'h60, bnd_pg = 8'h46;
  logic halt = 0, ld = 0;
  logic [7:0] ld_pg = 0;
  logic [7:0] cur_pg;
  logic valid = 0, sof = 0, eof = 0;
  logic [7:0] data = 0;
  logic busy, we, done;
  logic [15:0] addr;
  logic [7:0] wdata;

  int checks = 0, errors = 0, cycles = 0;
  int busy_cnt = 0, done_cnt = 0;
  logic [7:0] exp_pay[int];
  logic [7:0] exp_hdr[int];
  int model_cur = 0;

  always #2.5 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_pg(start_pg), .cfg_stop_pg(stop_pg),
    .cfg_bnd_pg(bnd_pg), .rx_halt(halt), .cur_wr_en(ld), .cur_wr_pg(ld_pg),
    .cur_pg(cur_pg), .frm_valid(valid), .frm_sof(sof), .frm_eof(eof),
    .frm_data(data), .frm_busy(busy), .mem_we(we), .mem_addr(addr),
    .mem_wdata(wdata), .rx_done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) done_cnt++;
      if (we) begin
        if (exp_pay.exists(int'(addr))) begin
          chk(wdata == exp_pay[int'(addr)], "R3 payload byte", wdata, exp_pay[int'(addr)]);
          exp_pay.delete(int'(addr));
        end else if (exp_hdr.exists(int'(addr))) begin
          chk(exp_pay.size() == 0, "R4 header after payload", exp_pay.size(), 0);
          chk(wdata == exp_hdr[int'(addr)], "R4/R5/R6 header byte", wdata, exp_hdr[int'(addr)]);
          exp_hdr.delete(int'(addr));
        end else begin
          chk(0, "R3/R9 unexpected write address", addr, 0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pbyte(int i, logic [7:0] d0);
    return (i == 0) ? d0 : 8'((i * 7 + 3) & 255);
  endfunction

  task automatic load_cur(input int pg, input int bnd);
    @(posedge clk); #1;
    ld = 1; ld_pg = 8'(pg); bnd_pg = 8'(bnd);
    @(posedge clk); #1;
    ld = 0;
    model_cur = pg;
    @(negedge clk);
    chk(cur_pg == 8'(pg), "R11 host load", cur_pg, pg);
  endtask

  task automatic frame(input int n, input logic [7:0] d0, input string tag);
    int st, sp, c, b, fp, base, a, nx;
    bit refused;
    st = int'(start_pg); sp = int'(stop_pg); c = model_cur; b = int'(bnd_pg);
    fp = (c < b) ? b - c : (sp - st) - (c - b);
    refused = halt || (sp <= st) || (fp * 256 < 1518);
    exp_pay.delete(); exp_hdr.delete();
    nx = c;
    if (!refused) begin
      base = (c >= 128) ? st : c;
      a = base * 256 + 4;
      for (int i = 0; i < n; i++) begin
        exp_pay[a] = pbyte(i, d0);
        a++;
        if (a == sp * 256) a = st * 256;
      end
      nx = base + (n + 8 + 255) / 256;
      if (nx >= sp) nx -= (sp - st);
      exp_hdr[base * 256]     = d0[0] ? 8'h21 : 8'h01;
      exp_hdr[base * 256 + 1] = 8'(nx);
      exp_hdr[base * 256 + 2] = 8'((n + 4) & 255);
      exp_hdr[base * 256 + 3] = 8'((n + 4) >> 8);
    end
    busy_cnt = 0; done_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 1; sof = (i == 0); eof = (i == n - 1); data = pbyte(i, d0);
    end
    @(posedge clk); #1;
    valid = 0; sof = 0; eof = 0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk(exp_pay.size() == 0, {tag, " all payload written"}, exp_pay.size(), 0);
    chk(exp_hdr.size() == 0, {tag, " all header written"}, exp_hdr.size(), 0);
    chk(busy_cnt == (refused ? 0 : 4), {tag, " R4 busy cycles"}, busy_cnt, refused ? 0 : 4);
    chk(done_cnt == (refused ? 0 : 1), {tag, " R7 done pulses"}, done_cnt, refused ? 0 : 1);
    chk(int'(cur_pg) == nx, {tag, " R7 current page"}, cur_pg, nx);
    model_cur = nx;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cur_pg == 0 && !busy && !we && !done, "R10 reset state", {cur_pg, busy, we, done}, 0);
    #1 rst_n = 1;
    load_cur(8'h46, 8'h46);
    frame(60, 8'h10, "R3 unicast");
    frame(300, 8'h01, "R5 multicast");
    load_cur(8'h5F, 8'h50);
    frame(600, 8'h22, "R3/R6 wrap");
    load_cur(8'h48, 8'h4A);
    frame(40, 8'h00, "R2/R9 full two pages");
    load_cur(8'h48, 8'h4D);
    frame(40, 8'h00, "R2 five pages refused");
    load_cur(8'h48, 8'h4E);
    frame(20, 8'h00, "R2 six pages accepted");
    halt = 1;
    frame(30, 8'h00, "R1 halted");
    halt = 0;
    stop_pg = 8'h46;
    frame(30, 8'h00, "R2 stop<=start");
    stop_pg = 8'h60;
    load_cur(8'h90, 8'h90);
    frame(10, 8'h03, "R8 fallback");
    load_cur(8'h50, 8'h50);
    frame(1514, 8'h04, "R6 max frame");
    frame(1, 8'h05, "R4 single byte");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule